// File: doc/BRIEF.md
# Processor Debug Control Unit

This block sits between a host byte link and a small processor under study. The host sends command bytes, and the unit turns them into clock control and observation. It can let the processor advance for an exact number of cycles or run freely until told to halt. It can also return a 32-bit word from any of eight observation points, two of which are spare probe lines that the integrator may wire to any internal net.

While the processor is halted, the unit drives override ports that load the program counter, write or read the register file, and write or read the instruction and data memories. A 32-bit result goes back to the host as four bytes, least significant first, on a valid/ready pair. It is assumed that while `ovr_active` is high the processor routes `ovr_rf_addr` to register read port 1. It is also assumed that both memories present read data one cycle after their read strobe.

Top module: `cpu_dbg_ctrl`

## Requirements
- R1: After reset, `core_clk_en`, `run_busy`, `cmd_err`, `rsp_valid` and all override strobes are low, and the selected observation source is 0.
- R2: Command byte 0x1_ (opcode in bits 7:4; bits 3:0 are ignored throughout) is followed by a 32-bit count sent least significant byte first. It holds `core_clk_en` high for exactly that many cycles, and a count of 0 gives no cycles.
- R3: Opcode 0x2 holds `core_clk_en` high until opcode 0x3 is decoded, and it is low from the cycle after that decode.
- R4: Opcode 0x4 takes one operand byte whose bits 2:0 pick the source: 0 program counter, 1 instruction memory output, 2 data memory output, 3 register port 1, 4 register port 2, 5 ALU result, 6 `probe0`, 7 `probe1`. Opcode 0xC returns the selected source.
- R5: Opcode 0x5 with 4 data bytes and no address produces a single-cycle `ovr_pc_we` carrying that data.
- R6: Opcode 0x6 (one address byte, low 5 bits used), 0x7 (instruction memory) and 0x8 (data memory) each take their address bytes followed by 4 data bytes. The memory opcodes take 2 address bytes, least significant first. Each produces one single-cycle write strobe with that address and data.
- R7: Opcodes 0x9 (one address byte), 0xA and 0xB (2 address bytes each) raise the matching read strobe for one cycle and return the register port 1 or memory output word.
- R8: A result appears as 4 bytes, least significant first, on `rsp_byte`. Each byte is held with `rsp_valid` until `rsp_ready` is seen, and no further bytes follow.
- R9: A write or read command arriving while the processor runs, or a read arriving while a result is still pending, consumes its operands, makes no strobe and no response, and sets `cmd_err`.
- R10: Opcodes 0x0 and 0xD to 0xF do nothing except set `cmd_err`. `cmd_err` stays set until the next command byte arrives.
- R11: `run_busy` equals `core_clk_en`, and `ovr_active` is high exactly when `run_busy` is low.
- R12: At most one override strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_valid | input | 1 | Host byte present this cycle |
| hst_byte | input | 8 | Host command or operand byte |
| rsp_valid | output | 1 | Response byte valid |
| rsp_byte | output | 8 | Response byte |
| rsp_ready | input | 1 | Host takes the response byte |
| core_clk_en | output | 1 | Processor clock enable |
| run_busy | output | 1 | Processor running |
| cmd_err | output | 1 | Last command rejected |
| ovr_active | output | 1 | Overrides own the processor ports |
| ovr_pc_we | output | 1 | Program counter load strobe |
| ovr_rf_we | output | 1 | Register file write strobe |
| ovr_rf_re | output | 1 | Register file read strobe |
| ovr_rf_addr | output | 5 | Register index |
| ovr_im_we | output | 1 | Instruction memory write strobe |
| ovr_im_re | output | 1 | Instruction memory read strobe |
| ovr_dm_we | output | 1 | Data memory write strobe |
| ovr_dm_re | output | 1 | Data memory read strobe |
| ovr_mem_addr | output | 16 | Memory address |
| ovr_wdata | output | 32 | Write data |
| obs_pc | input | 32 | Program counter |
| obs_im | input | 32 | Instruction memory output |
| obs_dm | input | 32 | Data memory output |
| obs_rf_a | input | 32 | Register read port 1 |
| obs_rf_b | input | 32 | Register read port 2 |
| obs_alu | input | 32 | ALU result |
| probe0 | input | 32 | Spare probe line |
| probe1 | input | 32 | Spare probe line |

## Verification
A command is decoded in the cycle after its last byte. Strobes and the start of clock enable follow one cycle later, and the first response byte follows three cycles after decode. The bench does not sample at fixed offsets. For runs it counts `core_clk_en` over a window longer than the requested count. For writes it counts strobes seen by edge monitors after a settling gap. For reads it waits for `rsp_valid` with a bounded timeout. All sampling happens on the falling edge.

// File: rtl/dbg_pkg.sv
// Package: opcode and source codes plus operand-length helpers for the debug unit.
// Assumes opcodes live in the upper nibble of a command byte.
package dbg_pkg;

    localparam logic [3:0] OP_STEP  = 4'h1;
    localparam logic [3:0] OP_RUN   = 4'h2;
    localparam logic [3:0] OP_HALT  = 4'h3;
    localparam logic [3:0] OP_SEL   = 4'h4;
    localparam logic [3:0] OP_WPC   = 4'h5;
    localparam logic [3:0] OP_WRF   = 4'h6;
    localparam logic [3:0] OP_WIM   = 4'h7;
    localparam logic [3:0] OP_WDM   = 4'h8;
    localparam logic [3:0] OP_RRF   = 4'h9;
    localparam logic [3:0] OP_RIM   = 4'hA;
    localparam logic [3:0] OP_RDM   = 4'hB;
    localparam logic [3:0] OP_RSEL  = 4'hC;

    localparam int NSRC = 8;
    localparam logic [2:0] SRC_PC  = 3'd0;
    localparam logic [2:0] SRC_IM  = 3'd1;
    localparam logic [2:0] SRC_DM  = 3'd2;
    localparam logic [2:0] SRC_RFA = 3'd3;

    typedef enum logic [1:0] {RD_IDLE, RD_ISSUE, RD_CAPT} rd_state_e;

    // Number of address bytes that precede the data bytes of an opcode.
    function automatic logic [3:0] op_addr_len(input logic [3:0] op, input logic [3:0] mem_ab);
        case (op)
            OP_WRF, OP_RRF:                 op_addr_len = 4'd1;
            OP_WIM, OP_WDM, OP_RIM, OP_RDM: op_addr_len = mem_ab;
            default:                        op_addr_len = 4'd0;
        endcase
    endfunction

    // Number of data bytes carried by an opcode.
    function automatic logic [3:0] op_data_len(input logic [3:0] op);
        case (op)
            OP_STEP, OP_WPC, OP_WRF, OP_WIM, OP_WDM: op_data_len = 4'd4;
            OP_SEL:                                  op_data_len = 4'd1;
            default:                                 op_data_len = 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/dbg_cmd_rx.sv
// Module: collects a command byte and its operands from the host link.
// Emits a one-cycle start pulse after the opcode byte and a one-cycle done
// pulse with opcode, address and data once the last operand has arrived.
// Assumes the host never pauses framing; every byte is taken when valid.
module dbg_cmd_rx
    import dbg_pkg::*;
#(
    parameter int ADDR_BYTES = 2,
    parameter int DATA_BYTES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [7:0]                in_byte,
    output logic                      cmd_start,
    output logic                      cmd_done,
    output logic [3:0]                cmd_op,
    output logic [ADDR_BYTES*8-1:0]   cmd_addr,
    output logic [DATA_BYTES*8-1:0]   cmd_data
);
    localparam logic [3:0] AB4 = 4'(ADDR_BYTES);

    logic       collecting_q;
    logic [3:0] alen_q, left_q, idx_q;
    logic [3:0] new_alen, new_len, didx;

    // Operand lengths of an incoming opcode byte and the data index of an operand.
    always_comb begin
        new_alen = op_addr_len(in_byte[7:4], AB4);
        new_len  = new_alen + op_data_len(in_byte[7:4]);
        didx     = idx_q - alen_q;
    end

    // Framing: opcode capture, operand placement and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            collecting_q <= 1'b0;
            alen_q       <= '0;
            left_q       <= '0;
            idx_q        <= '0;
            cmd_op       <= '0;
            cmd_addr     <= '0;
            cmd_data     <= '0;
            cmd_start    <= 1'b0;
            cmd_done     <= 1'b0;
        end else begin
            cmd_start <= 1'b0;
            cmd_done  <= 1'b0;
            if (in_valid) begin
                if (!collecting_q) begin
                    cmd_op    <= in_byte[7:4];
                    cmd_start <= 1'b1;
                    cmd_addr  <= '0;
                    cmd_data  <= '0;
                    idx_q     <= '0;
                    alen_q    <= new_alen;
                    if (new_len == 4'd0) begin
                        cmd_done <= 1'b1;
                    end else begin
                        collecting_q <= 1'b1;
                        left_q       <= new_len;
                    end
                end else begin
                    for (int k = 0; k < ADDR_BYTES; k++) begin
                        if (idx_q == 4'(k) && idx_q < alen_q)
                            cmd_addr[k*8 +: 8] <= in_byte;
                    end
                    for (int k = 0; k < DATA_BYTES; k++) begin
                        if (didx == 4'(k) && idx_q >= alen_q)
                            cmd_data[k*8 +: 8] <= in_byte;
                    end
                    idx_q  <= idx_q + 4'd1;
                    left_q <= left_q - 4'd1;
                    if (left_q == 4'd1) begin
                        collecting_q <= 1'b0;
                        cmd_done     <= 1'b1;
                    end
                end
            end
        end
    end

    // R2: a completed command never coincides with a new opcode start unless it has no operands
    a_r2_done_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (collecting_q && in_valid && left_q == 4'd1) |=> (cmd_done && !cmd_start));

endmodule

// File: rtl/dbg_run_gate.sv
// Module: processor clock-enable gate with counted and free-running modes.
// Assumes at most one of step/run/halt is requested per cycle.
module dbg_run_gate #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_go,
    input  logic             run_go,
    input  logic             halt_go,
    input  logic [CNT_W-1:0] step_cnt,
    output logic             running
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic             free_q;
    logic [CNT_W-1:0] left_q;

    // Run state: halt wins, then free run, then counted load, then countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            free_q  <= 1'b0;
            left_q  <= '0;
        end else if (halt_go) begin
            running <= 1'b0;
            free_q  <= 1'b0;
        end else if (run_go) begin
            running <= 1'b1;
            free_q  <= 1'b1;
        end else if (step_go) begin
            free_q  <= 1'b0;
            left_q  <= step_cnt;
            running <= (step_cnt != '0);
        end else if (running && !free_q) begin
            left_q <= left_q - ONE;
            if (left_q == ONE) running <= 1'b0;
        end
    end

    // R2: a zero count leaves the processor stopped
    a_r2_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (step_go && !halt_go && !run_go && step_cnt == '0) |=> !running);
    // R2: the last counted cycle ends the run
    a_r2_last_step: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !free_q && left_q == ONE && !step_go && !run_go && !halt_go) |=> !running);
    // R3: halt stops the clock on the next cycle
    a_r3_halt: assert property (@(posedge clk) disable iff (!rst_n)
        halt_go |=> !running);
    // R3: free run persists without a halt
    a_r3_free_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (running && free_q && !halt_go && !step_go) |=> running);

endmodule

// File: rtl/dbg_obs_mux.sv
// Module: eight-way observation selector. Purely combinational.
// Assumes all sources share one width.
module dbg_obs_mux
    import dbg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] src [NSRC],
    input  logic [2:0]        sel,
    output logic [DATA_W-1:0] word
);
    // Pick the addressed source.
    always_comb word = src[sel];
endmodule

// File: rtl/dbg_rsp_tx.sv
// Module: sends a loaded word to the host as bytes, least significant first,
// each held until the host accepts it. Assumes load only while idle.
module dbg_rsp_tx #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] word,
    output logic              out_valid,
    output logic [7:0]        out_byte,
    input  logic              out_ready
);
    localparam int NB  = DATA_W / 8;
    localparam int IW  = (NB > 1) ? $clog2(NB) : 1;
    localparam logic [IW-1:0] LAST = IW'(NB - 1);

    logic [DATA_W-1:0] word_q;
    logic [IW-1:0]     idx_q;

    // Byte sequencing with a valid/ready hand-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            word_q    <= '0;
            idx_q     <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            word_q    <= word;
            idx_q     <= '0;
        end else if (out_valid && out_ready) begin
            if (idx_q == LAST) out_valid <= 1'b0;
            else               idx_q <= idx_q + IW'(1);
        end
    end

    // Current byte lane.
    always_comb begin
        out_byte = '0;
        for (int k = 0; k < NB; k++)
            if (idx_q == IW'(k)) out_byte = word_q[k*8 +: 8];
    end

    // R8: an unaccepted byte stays valid and unchanged
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !load) |=> (out_valid && $stable(out_byte)));

endmodule

// File: rtl/cpu_dbg_ctrl.sv
// Module: top of the processor debug unit. Decodes host commands, gates the
// processor clock, drives override strobes while halted and returns observed
// words. Assumes register port 1 follows ovr_rf_addr while halted and both
// memories return read data one cycle after the read strobe.
module cpu_dbg_ctrl
    import dbg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16,
    parameter int RF_AW  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hst_valid,
    input  logic [7:0]        hst_byte,
    output logic              rsp_valid,
    output logic [7:0]        rsp_byte,
    input  logic              rsp_ready,
    output logic              core_clk_en,
    output logic              run_busy,
    output logic              cmd_err,
    output logic              ovr_active,
    output logic              ovr_pc_we,
    output logic              ovr_rf_we,
    output logic              ovr_rf_re,
    output logic [RF_AW-1:0]  ovr_rf_addr,
    output logic              ovr_im_we,
    output logic              ovr_im_re,
    output logic              ovr_dm_we,
    output logic              ovr_dm_re,
    output logic [ADDR_W-1:0] ovr_mem_addr,
    output logic [DATA_W-1:0] ovr_wdata,
    input  logic [DATA_W-1:0] obs_pc,
    input  logic [DATA_W-1:0] obs_im,
    input  logic [DATA_W-1:0] obs_dm,
    input  logic [DATA_W-1:0] obs_rf_a,
    input  logic [DATA_W-1:0] obs_rf_b,
    input  logic [DATA_W-1:0] obs_alu,
    input  logic [DATA_W-1:0] probe0,
    input  logic [DATA_W-1:0] probe1
);
    localparam int ADDR_BYTES = (ADDR_W + 7) / 8;
    localparam int DATA_BYTES = DATA_W / 8;

    logic                    c_start, c_done;
    logic [3:0]              c_op;
    logic [ADDR_BYTES*8-1:0] c_addr;
    logic [DATA_W-1:0]       c_data;
    logic                    step_go, run_go, halt_go;
    logic                    running;
    logic                    tx_load;
    logic [DATA_W-1:0]       tx_word;
    logic [DATA_W-1:0]       srcs [NSRC];
    logic [2:0]              sel_q, rd_src_q;
    rd_state_e               rd_q;
    logic                    is_write, is_read, is_known, accept_w, accept_r, reject;

    dbg_cmd_rx #(.ADDR_BYTES(ADDR_BYTES), .DATA_BYTES(DATA_BYTES)) u_rx (
        .clk(clk), .rst_n(rst_n), .in_valid(hst_valid), .in_byte(hst_byte),
        .cmd_start(c_start), .cmd_done(c_done), .cmd_op(c_op),
        .cmd_addr(c_addr), .cmd_data(c_data)
    );

    // Run-control requests from decoded commands.
    always_comb begin
        step_go = c_done && (c_op == OP_STEP);
        run_go  = c_done && (c_op == OP_RUN);
        halt_go = c_done && (c_op == OP_HALT);
    end

    dbg_run_gate #(.CNT_W(DATA_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .step_go(step_go), .run_go(run_go),
        .halt_go(halt_go), .step_cnt(c_data), .running(running)
    );

    assign core_clk_en = running;
    assign run_busy    = running;
    assign ovr_active  = !running;

    // Observation sources in select-code order.
    always_comb begin
        srcs[0] = obs_pc;
        srcs[1] = obs_im;
        srcs[2] = obs_dm;
        srcs[3] = obs_rf_a;
        srcs[4] = obs_rf_b;
        srcs[5] = obs_alu;
        srcs[6] = probe0;
        srcs[7] = probe1;
    end

    dbg_obs_mux #(.DATA_W(DATA_W)) u_mux (.src(srcs), .sel(rd_src_q), .word(tx_word));

    assign tx_load = (rd_q == RD_CAPT);

    dbg_rsp_tx #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(tx_load), .word(tx_word),
        .out_valid(rsp_valid), .out_byte(rsp_byte), .out_ready(rsp_ready)
    );

    // Command class and acceptance.
    always_comb begin
        is_write = (c_op == OP_WPC) || (c_op == OP_WRF) || (c_op == OP_WIM) || (c_op == OP_WDM);
        is_read  = (c_op == OP_RRF) || (c_op == OP_RIM) || (c_op == OP_RDM) || (c_op == OP_RSEL);
        is_known = is_write || is_read || (c_op == OP_STEP) || (c_op == OP_RUN) ||
                   (c_op == OP_HALT) || (c_op == OP_SEL);
        accept_w = c_done && is_write && !running;
        accept_r = c_done && is_read && !running && (rd_q == RD_IDLE) && !rsp_valid;
        reject   = c_done && ((is_write && !accept_w) || (is_read && !accept_r) || !is_known);
    end

    // Override strobes, address/data registers, source select and read sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_pc_we    <= 1'b0;
            ovr_rf_we    <= 1'b0;
            ovr_rf_re    <= 1'b0;
            ovr_im_we    <= 1'b0;
            ovr_im_re    <= 1'b0;
            ovr_dm_we    <= 1'b0;
            ovr_dm_re    <= 1'b0;
            ovr_rf_addr  <= '0;
            ovr_mem_addr <= '0;
            ovr_wdata    <= '0;
            sel_q        <= SRC_PC;
            rd_src_q     <= SRC_PC;
            rd_q         <= RD_IDLE;
        end else begin
            ovr_pc_we <= 1'b0;
            ovr_rf_we <= 1'b0;
            ovr_rf_re <= 1'b0;
            ovr_im_we <= 1'b0;
            ovr_im_re <= 1'b0;
            ovr_dm_we <= 1'b0;
            ovr_dm_re <= 1'b0;
            case (rd_q)
                RD_ISSUE: rd_q <= RD_CAPT;
                RD_CAPT:  rd_q <= RD_IDLE;
                default:  rd_q <= RD_IDLE;
            endcase
            if (c_done && c_op == OP_SEL) sel_q <= c_data[2:0];
            if (accept_w) begin
                ovr_wdata <= c_data;
                case (c_op)
                    OP_WPC: ovr_pc_we <= 1'b1;
                    OP_WRF: begin
                        ovr_rf_we   <= 1'b1;
                        ovr_rf_addr <= c_addr[RF_AW-1:0];
                    end
                    OP_WIM: begin
                        ovr_im_we    <= 1'b1;
                        ovr_mem_addr <= c_addr[ADDR_W-1:0];
                    end
                    default: begin
                        ovr_dm_we    <= 1'b1;
                        ovr_mem_addr <= c_addr[ADDR_W-1:0];
                    end
                endcase
            end
            if (accept_r) begin
                rd_q <= RD_ISSUE;
                case (c_op)
                    OP_RRF: begin
                        ovr_rf_re   <= 1'b1;
                        ovr_rf_addr <= c_addr[RF_AW-1:0];
                        rd_src_q    <= SRC_RFA;
                    end
                    OP_RIM: begin
                        ovr_im_re    <= 1'b1;
                        ovr_mem_addr <= c_addr[ADDR_W-1:0];
                        rd_src_q     <= SRC_IM;
                    end
                    OP_RDM: begin
                        ovr_dm_re    <= 1'b1;
                        ovr_mem_addr <= c_addr[ADDR_W-1:0];
                        rd_src_q     <= SRC_DM;
                    end
                    default: rd_src_q <= sel_q;
                endcase
            end
        end
    end

    // Error flag: cleared by a new command byte, set by a rejected command.
    always_ff @(posedge clk) begin
        if (!rst_n)        cmd_err <= 1'b0;
        else if (reject)   cmd_err <= 1'b1;
        else if (c_start)  cmd_err <= 1'b0;
    end

    // R12: strobes are mutually exclusive
    a_r12_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ovr_pc_we, ovr_rf_we, ovr_rf_re, ovr_im_we, ovr_im_re, ovr_dm_we, ovr_dm_re}));
    // R9: no override strobe while the processor runs
    a_r9_halted_only: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_pc_we || ovr_rf_we || ovr_rf_re || ovr_im_we || ovr_im_re || ovr_dm_we || ovr_dm_re)
        |-> ovr_active);
    // R7: a captured read result is offered to the host on the next cycle
    a_r7_capture_sends: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_q == RD_CAPT) |=> rsp_valid);
    // R10: a rejected command leaves the error flag set
    a_r10_err_set: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> cmd_err);

endmodule

// File: tb/cpu_dbg_ctrl_bench.sv
// Bench: vector table for source reads and counted runs, then directed tests.
module cpu_dbg_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        hst_valid = 1'b0;
    logic [7:0]  hst_byte = '0;
    logic        rsp_ready = 1'b1;
    logic        rsp_valid, core_clk_en, run_busy, cmd_err, ovr_active;
    logic [7:0]  rsp_byte;
    logic        ovr_pc_we, ovr_rf_we, ovr_rf_re, ovr_im_we, ovr_im_re, ovr_dm_we, ovr_dm_re;
    logic [4:0]  ovr_rf_addr;
    logic [15:0] ovr_mem_addr;
    logic [31:0] ovr_wdata;
    logic [31:0] pc_m, im_q, dm_q;
    logic [31:0] rf [32];
    logic [31:0] im [256];
    logic [31:0] dm [256];
    logic [31:0] obs_rf_a;

    assign obs_rf_a = rf[ovr_rf_addr];

    cpu_dbg_ctrl u_cpu_dbg_ctrl (
        .clk(clk), .rst_n(rst_n), .hst_valid(hst_valid), .hst_byte(hst_byte),
        .rsp_valid(rsp_valid), .rsp_byte(rsp_byte), .rsp_ready(rsp_ready),
        .core_clk_en(core_clk_en), .run_busy(run_busy), .cmd_err(cmd_err),
        .ovr_active(ovr_active), .ovr_pc_we(ovr_pc_we), .ovr_rf_we(ovr_rf_we),
        .ovr_rf_re(ovr_rf_re), .ovr_rf_addr(ovr_rf_addr), .ovr_im_we(ovr_im_we),
        .ovr_im_re(ovr_im_re), .ovr_dm_we(ovr_dm_we), .ovr_dm_re(ovr_dm_re),
        .ovr_mem_addr(ovr_mem_addr), .ovr_wdata(ovr_wdata),
        .obs_pc(pc_m), .obs_im(im_q), .obs_dm(dm_q), .obs_rf_a(obs_rf_a),
        .obs_rf_b(32'h2222_0002), .obs_alu(32'h5555_0005),
        .probe0(32'h6666_0006), .probe1(32'h7777_0007)
    );

    int n_pc = 0, n_rfw = 0, n_rfr = 0, n_imw = 0, n_imr = 0, n_dmw = 0, n_dmr = 0;
    logic [31:0] last_pc = '0;

    // Processor-side models and strobe monitors.
    initial begin
        pc_m = 32'h0000_0400;
        im_q = 32'h1111_0001;
        dm_q = 32'h3333_0003;
        for (int i = 0; i < 32; i++) rf[i] = 32'hA000_0000 + i;
        for (int i = 0; i < 256; i++) begin
            im[i] = 32'hB000_0000 + i;
            dm[i] = 32'hC000_0000 + i;
        end
    end

    always @(posedge clk) begin
        if (ovr_pc_we) begin pc_m <= ovr_wdata; last_pc <= ovr_wdata; n_pc <= n_pc + 1; end
        if (ovr_rf_we) begin rf[ovr_rf_addr] <= ovr_wdata; n_rfw <= n_rfw + 1; end
        if (ovr_rf_re) n_rfr <= n_rfr + 1;
        if (ovr_im_we) begin im[ovr_mem_addr[7:0]] <= ovr_wdata; n_imw <= n_imw + 1; end
        if (ovr_im_re) begin im_q <= im[ovr_mem_addr[7:0]]; n_imr <= n_imr + 1; end
        if (ovr_dm_we) begin dm[ovr_mem_addr[7:0]] <= ovr_wdata; n_dmw <= n_dmw + 1; end
        if (ovr_dm_re) begin dm_q <= dm[ovr_mem_addr[7:0]]; n_dmr <= n_dmr + 1; end
    end

    int tests = 0, fails = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        hst_valid = 1'b1;
        hst_byte  = b;
        @(negedge clk);
        hst_valid = 1'b0;
    endtask

    task automatic send_word(input logic [31:0] w);
        for (int i = 0; i < 4; i++) send_byte(w[i*8 +: 8]);
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic get_word(output logic [31:0] w, output bit ok);
        w  = '0;
        ok = 1'b1;
        for (int b = 0; b < 4; b++) begin
            int t = 0;
            while (!rsp_valid && t < 40) begin @(negedge clk); t++; end
            if (!rsp_valid) ok = 1'b0;
            w[b*8 +: 8] = rsp_byte;
            @(negedge clk);
        end
    endtask

    // Counted run: returns enable-high cycles; checks R11 every sample.
    task automatic count_run(input int window, output int n, output bit r11_ok);
        n = 0;
        r11_ok = 1'b1;
        for (int i = 0; i < window; i++) begin
            @(negedge clk);
            if (core_clk_en) n++;
            if (run_busy != core_clk_en || ovr_active == run_busy) r11_ok = 1'b0;
        end
    endtask

    // kind 0: select source arg, read it, expect exp; kind 1: step arg cycles.
    localparam int NV = 14;
    localparam logic [67:0] VEC [NV] = '{
        {4'd0, 32'h0000_0000, 32'h0000_0400},
        {4'd0, 32'h0000_0001, 32'h1111_0001},
        {4'd0, 32'h0000_0002, 32'h3333_0003},
        {4'd0, 32'h0000_0003, 32'hA000_0000},
        {4'd0, 32'h0000_0004, 32'h2222_0002},
        {4'd0, 32'h0000_0005, 32'h5555_0005},
        {4'd0, 32'h0000_0006, 32'h6666_0006},
        {4'd0, 32'h0000_0007, 32'h7777_0007},
        {4'd0, 32'h0000_00F9, 32'h1111_0001},
        {4'd1, 32'h0000_0000, 32'h0000_0000},
        {4'd1, 32'h0000_0001, 32'h0000_0001},
        {4'd1, 32'h0000_0005, 32'h0000_0005},
        {4'd1, 32'h0000_0025, 32'h0000_0025},
        {4'd1, 32'h0000_0100, 32'h0000_0100}
    };

    initial begin
        logic [31:0] w;
        bit ok, r11;
        int n, base;

        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(1);
        // R1: reset state
        chk(!core_clk_en && !run_busy, "R1 clock idle", {31'd0, core_clk_en}, 32'd0);
        chk(!rsp_valid && !cmd_err && ovr_active, "R1 flags", {29'd0, rsp_valid, cmd_err, ovr_active}, 32'd1);
        chk(!(ovr_pc_we | ovr_rf_we | ovr_im_we | ovr_dm_we | ovr_rf_re | ovr_im_re | ovr_dm_re),
            "R1 strobes", 32'd0, 32'd0);
        send_byte(8'hC0);
        get_word(w, ok);
        chk(ok && w == 32'h0000_0400, "R1 default source", w, 32'h0000_0400);

        for (int v = 0; v < NV; v++) begin
            if (VEC[v][67:64] == 4'd0) begin
                send_byte(8'h40);
                send_byte(VEC[v][39:32]);
                send_byte(8'hC3);
                get_word(w, ok);
                chk(ok && w == VEC[v][31:0], "R4 source read", w, VEC[v][31:0]);
                wait_cyc(3);
                chk(!rsp_valid, "R8 no extra bytes", {31'd0, rsp_valid}, 32'd0);
            end else begin
                send_byte(8'h1A);
                send_word(VEC[v][63:32]);
                count_run(int'(VEC[v][63:32]) + 10, n, r11);
                chk(n == int'(VEC[v][31:0]), "R2 step count", n, VEC[v][31:0]);
                chk(r11, "R11 busy and override track enable", {31'd0, r11}, 32'd1);
            end
        end

        // R5: program counter write, no address
        base = n_pc;
        send_byte(8'h50);
        send_word(32'hDEAD_0100);
        wait_cyc(3);
        chk(n_pc == base + 1 && last_pc == 32'hDEAD_0100, "R5 pc write", last_pc, 32'hDEAD_0100);
        send_byte(8'h40); send_byte(8'h00); send_byte(8'hC0);
        get_word(w, ok);
        chk(ok && w == 32'hDEAD_0100, "R5 pc readback", w, 32'hDEAD_0100);

        // R6/R7: register file
        send_byte(8'h60); send_byte(8'hE5); send_word(32'h0BAD_F00D);
        wait_cyc(3);
        chk(n_rfw == 1 && ovr_rf_addr == 5'd5, "R6 reg write", {27'd0, ovr_rf_addr}, 32'd5);
        send_byte(8'h90); send_byte(8'h05);
        get_word(w, ok);
        chk(ok && w == 32'h0BAD_F00D && n_rfr == 1, "R7 reg read", w, 32'h0BAD_F00D);

        // R6/R7: instruction and data memories with two address bytes
        send_byte(8'h70); send_byte(8'h23); send_byte(8'h01); send_word(32'h1234_5678);
        send_byte(8'h80); send_byte(8'h23); send_byte(8'h01); send_word(32'h8765_4321);
        wait_cyc(3);
        chk(n_imw == 1 && n_dmw == 1 && ovr_mem_addr == 16'h0123, "R6 mem writes", {16'd0, ovr_mem_addr}, 32'h0123);
        send_byte(8'hA0); send_byte(8'h23); send_byte(8'h01);
        get_word(w, ok);
        chk(ok && w == 32'h1234_5678 && n_imr == 1, "R7 imem read", w, 32'h1234_5678);
        send_byte(8'hB0); send_byte(8'h23); send_byte(8'h01);
        get_word(w, ok);
        chk(ok && w == 32'h8765_4321 && n_dmr == 1, "R7 dmem read", w, 32'h8765_4321);

        // R3: free run until halt
        send_byte(8'h2F);
        count_run(30, n, r11);
        chk(n >= 28 && core_clk_en, "R3 free run holds", n, 32'd28);
        send_byte(8'h31);
        wait_cyc(2);
        chk(!core_clk_en && !run_busy && ovr_active, "R3 halt", {31'd0, core_clk_en}, 32'd0);

        // R9: write while running is dropped, operands consumed, error set
        send_byte(8'h10); send_word(32'd60);
        base = n_pc;
        send_byte(8'h50); send_word(32'hFFFF_FFFF);
        wait_cyc(2);
        chk(cmd_err, "R9 write rejected flag", {31'd0, cmd_err}, 32'd1);
        send_byte(8'h90); send_byte(8'h05);
        wait_cyc(6);
        chk(!rsp_valid && n_rfr == 1, "R9 read while running", {31'd0, rsp_valid}, 32'd0);
        wait_cyc(60);
        chk(!run_busy && n_pc == base && cmd_err, "R9 no strobe, flag sticky", n_pc, base);
        send_byte(8'h40); send_byte(8'h00);
        wait_cyc(2);
        chk(!cmd_err, "R10 flag cleared by next command", {31'd0, cmd_err}, 32'd0);
        send_byte(8'hC0);
        get_word(w, ok);
        chk(ok && w == 32'hDEAD_0100, "R9 pc unchanged and framing intact", w, 32'hDEAD_0100);

        // R10: unknown opcodes
        send_byte(8'hD5);
        wait_cyc(2);
        chk(cmd_err && !run_busy && !rsp_valid && n_pc == base, "R10 unknown opcode D", {31'd0, cmd_err}, 32'd1);
        send_byte(8'h07);
        wait_cyc(2);
        chk(cmd_err && !run_busy, "R10 unknown opcode 0", {31'd0, cmd_err}, 32'd1);

        // R8: byte held while host is not ready; second read rejected (R9)
        rsp_ready = 1'b0;
        send_byte(8'h40); send_byte(8'h05); send_byte(8'hC0);
        wait_cyc(8);
        chk(rsp_valid && rsp_byte == 8'h05, "R8 byte held", {24'd0, rsp_byte}, 32'h05);
        send_byte(8'hC0);
        wait_cyc(2);
        chk(cmd_err, "R9 read while response pending", {31'd0, cmd_err}, 32'd1);
        rsp_ready = 1'b1;
        get_word(w, ok);
        chk(ok && w == 32'h5555_0005, "R8 word order", w, 32'h5555_0005);
        wait_cyc(10);
        chk(!rsp_valid, "R8 exactly four bytes", {31'd0, rsp_valid}, 32'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule